// File: doc/BRIEF.md
# Link Speed Upgrade Decision Controller

This block works next to a serial link training state machine. It decides when the port should ask to move the link between 2.5 GT/s and 5.0 GT/s. It keeps a record of which rates the link partner most recently said it supports. That record is taken only from training sets received during the two training states where capture is allowed. Using the record, the block works out which speeds to advertise and, from the port's role and the software controls, whether a rate change is needed.

There are three reasons for a change, in this priority order:

1. A software retrain whose target speed differs from the current speed.
2. A reliability-driven downgrade request.
3. An automatic upgrade to 5.0 GT/s. Only a downstream-facing port makes this upgrade, once per data-link-active period, after the data link comes up.

The request is held until the training machine acknowledges it. When a software-directed or reliability-driven change completes, the block raises a bandwidth-management status flag. The automatic upgrade never raises this flag.

Speed codes used on every speed port: `2'b01` is 2.5 GT/s and `2'b10` is 5.0 GT/s. A target code other than `2'b10` is treated as 2.5 GT/s. In the rate-support vectors, bit 0 means 2.5 GT/s and bit 1 means 5.0 GT/s.

Top module: `link_rate_ctrl`

## Requirements
- R1: `partner_caps` changes only at a clock edge where `ts_valid` is high together with `st_cfg_done` or `st_rcvr_cfg`. At other edges it holds its value.
- R2: At a capture edge, `partner_caps` becomes `{rx_rate_id[1], 1'b1}`. Bit 0 (2.5 GT/s) is always set. Each capture fully replaces the previous value, including a drop from `2'b11` to `2'b01`.
- R3: After reset, `partner_caps` is `2'b01`. `adv_speeds` is `2'b11` when `tgt_speed` is `2'b10`, and `2'b01` otherwise.
- R4: A downstream-facing port (`port_is_dsp`=1) issues a request for `2'b10` one edge after all of the following hold: `dl_active` is high, `tgt_speed` is `2'b10`, `partner_caps[1]` is set, `cur_speed` is `2'b01`, and `init_upg_dis` is low.
- R5: No automatic request is made by an upstream-facing port (`port_is_dsp`=0), or while `init_upg_dis` is set.
- R6: The automatic upgrade fires at most once per period of `dl_active` being high. It re-arms only when `dl_active` goes low, or on reset.
- R7: When accepted, a retrain requests `tgt_speed` if it differs from `cur_speed` and the partner supports it. A target of `2'b10` with `partner_caps[1]`=0 makes no request.
- R8: A `retrain_wr` pulse sets `link_retrain`. The retrain is accepted at the first edge where no request is outstanding, and `link_retrain` clears at that same edge.
- R9: A `rel_down_req` pulse while `cur_speed` is `2'b10` requests `2'b01`. At 2.5 GT/s, or while a request is outstanding, it is ignored.
- R10: `chg_req` and `chg_speed` hold until an edge where `chg_ack` is high. `chg_req` is low after that edge.
- R11: `bw_sts` is set at the acknowledge edge of a retrain-caused or reliability-caused request. It is not set for an automatic upgrade, and it is cleared by `bw_sts_clr`.
- R12: When a pending retrain and an automatic upgrade are both eligible at the same edge, the retrain is served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_rate_id | input | 2 | Rate-support bits from the received training set |
| ts_valid | input | 1 | A training set was received this cycle |
| st_cfg_done | input | 1 | Training machine is in the configuration-complete state |
| st_rcvr_cfg | input | 1 | Training machine is in the recovery receiver-configuration state |
| dl_active | input | 1 | Data link layer is active |
| port_is_dsp | input | 1 | 1 = downstream-facing port, 0 = upstream-facing |
| tgt_speed | input | 2 | Target link speed code |
| retrain_wr | input | 1 | Pulse that sets the retrain bit |
| init_upg_dis | input | 1 | Disables the automatic initial upgrade |
| rel_down_req | input | 1 | Reliability-driven downgrade request pulse |
| cur_speed | input | 2 | Current link speed code |
| chg_ack | input | 1 | Training machine accepts the speed-change request |
| bw_sts_clr | input | 1 | Clears the bandwidth-management status flag |
| chg_req | output | 1 | Speed-change request to the training machine |
| chg_speed | output | 2 | Speed requested by `chg_req` |
| adv_speeds | output | 2 | Speeds to advertise in transmitted training sets |
| partner_caps | output | 2 | Recorded partner rate support |
| link_retrain | output | 1 | Retrain bit, pending until accepted |
| bw_sts | output | 1 | Bandwidth-management status flag |

## Verification
The bound assertions check the following on every cycle:

- The capture record only moves at a qualifying training-set edge, and always takes the newest bits.
- A rising request for 5.0 GT/s is always backed by a recorded partner advertisement.
- The request stays stable until acknowledged and drops right after.
- A request raised without a retrain or reliability cause comes only from a downstream-facing port.
- The retrain bit clears once it is accepted.

Some behaviour can only be shown by the bench's scenarios, because it depends on history:

- The once-per-active-period rule and its re-arm.
- The status flag staying clear after an automatic upgrade but rising after a retrain or downgrade.
- A retrain waiting behind an outstanding request.
- Retrain winning over the automatic upgrade.

// File: rtl/lrc_pkg.sv
// Package: shared speed codes and request-cause type for the link rate controller.
// Assumes speed fields use one-hot style codes: 01 = 2.5 GT/s, 10 = 5.0 GT/s.
package lrc_pkg;
    localparam int SPD_W = 2;
    localparam logic [SPD_W-1:0] SPD_GEN1 = 2'b01;
    localparam logic [SPD_W-1:0] SPD_GEN2 = 2'b10;
    localparam logic [SPD_W-1:0] CAPS_ALL = 2'b11;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_AUTO = 2'd1,
        SRC_SW   = 2'd2,
        SRC_REL  = 2'd3
    } chg_src_e;
endpackage

// File: rtl/lrc_partner_caps.sv
// Module: records the partner's advertised rates.
// Capture happens only on training sets seen in the two permitted states; the
// newest capture always wins. 2.5 GT/s support is forced on.
module lrc_partner_caps
    import lrc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ts_valid,
    input  logic             st_cfg_done,
    input  logic             st_rcvr_cfg,
    input  logic [SPD_W-1:0] rx_rate_id,
    output logic [SPD_W-1:0] caps
);
    logic take;

    // Qualify capture by training state.
    assign take = ts_valid && (st_cfg_done || st_rcvr_cfg);

    // Latest-wins record of partner support.
    always_ff @(posedge clk) begin
        if (!rst_n)
            caps <= SPD_GEN1;
        else if (take)
            caps <= {rx_rate_id[1], rx_rate_id[0] | 1'b1};
    end
endmodule

// File: rtl/lrc_arbiter.sv
// Module: decides whether a speed change is needed this cycle.
// Holds the retrain bit and the once-per-active-period automatic upgrade flag.
// Priority: retrain, then reliability downgrade, then automatic upgrade.
// Assumes 'busy' is high while a request is outstanding; nothing new issues then.
module lrc_arbiter
    import lrc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             partner_gen2,
    input  logic [SPD_W-1:0] tgt_speed,
    input  logic [SPD_W-1:0] cur_speed,
    input  logic             dl_active,
    input  logic             port_is_dsp,
    input  logic             init_upg_dis,
    input  logic             retrain_wr,
    input  logic             rel_down_req,
    input  logic             busy,
    output logic             link_retrain,
    output logic             issue,
    output logic [SPD_W-1:0] issue_speed,
    output chg_src_e         issue_src
);
    logic lt_q;
    logic auto_done_q;
    logic tgt_gen2, cur_gen2, tgt_ok;
    logic lt_accept, sw_fire, rel_fire, auto_fire;

    // Decode speed codes and partner support for the target.
    assign tgt_gen2 = (tgt_speed == SPD_GEN2);
    assign cur_gen2 = (cur_speed == SPD_GEN2);
    assign tgt_ok   = !tgt_gen2 || partner_gen2;

    // Per-cause fire conditions, ordered by priority.
    always_comb begin
        lt_accept = lt_q && !busy;
        sw_fire   = lt_accept && (tgt_gen2 != cur_gen2) && tgt_ok;
        rel_fire  = !busy && !lt_q && rel_down_req && cur_gen2;
        auto_fire = !busy && !lt_q && dl_active && port_is_dsp && !init_upg_dis
                    && tgt_gen2 && partner_gen2 && !cur_gen2 && !auto_done_q;
    end

    // Select the request to issue.
    always_comb begin
        issue       = sw_fire || rel_fire || auto_fire;
        issue_speed = SPD_GEN2;
        issue_src   = SRC_NONE;
        if (sw_fire) begin
            issue_speed = tgt_gen2 ? SPD_GEN2 : SPD_GEN1;
            issue_src   = SRC_SW;
        end else if (rel_fire) begin
            issue_speed = SPD_GEN1;
            issue_src   = SRC_REL;
        end else if (auto_fire) begin
            issue_speed = SPD_GEN2;
            issue_src   = SRC_AUTO;
        end
    end

    // Retrain bit: a write sets it, acceptance clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lt_q <= 1'b0;
        else if (retrain_wr)
            lt_q <= 1'b1;
        else if (lt_accept)
            lt_q <= 1'b0;
    end

    // Automatic upgrade fires once per data-link-active period.
    always_ff @(posedge clk) begin
        if (!rst_n)
            auto_done_q <= 1'b0;
        else if (!dl_active)
            auto_done_q <= 1'b0;
        else if (auto_fire)
            auto_done_q <= 1'b1;
    end

    assign link_retrain = lt_q;
endmodule

// File: rtl/lrc_req_hold.sv
// Module: holds the speed-change request until acknowledged and keeps the
// bandwidth-management status flag. Only software or reliability causes set
// the flag, at the acknowledge edge.
module lrc_req_hold
    import lrc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue,
    input  logic [SPD_W-1:0] issue_speed,
    input  chg_src_e         issue_src,
    input  logic             chg_ack,
    input  logic             bw_sts_clr,
    output logic             chg_req,
    output logic [SPD_W-1:0] chg_speed,
    output logic             bw_sts
);
    chg_src_e src_q;
    logic     done;
    logic     flag_cause;

    // Completion of the outstanding request and whether it counts for status.
    assign done       = chg_req && chg_ack;
    assign flag_cause = (src_q == SRC_SW) || (src_q == SRC_REL);

    // Request register: load on issue, drop on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chg_req   <= 1'b0;
            chg_speed <= SPD_GEN1;
            src_q     <= SRC_NONE;
        end else if (done) begin
            chg_req <= 1'b0;
            src_q   <= SRC_NONE;
        end else if (issue && !chg_req) begin
            chg_req   <= 1'b1;
            chg_speed <= issue_speed;
            src_q     <= issue_src;
        end
    end

    // Status flag: set beats clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bw_sts <= 1'b0;
        else if (done && flag_cause)
            bw_sts <= 1'b1;
        else if (bw_sts_clr)
            bw_sts <= 1'b0;
    end
endmodule

// File: rtl/link_rate_ctrl.sv
// Top: link speed upgrade decision controller.
// Combines partner rate capture, the change decision and the request holder.
// Assumes the port itself supports both rates; the advertised set follows the
// target speed field.
module link_rate_ctrl
    import lrc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SPD_W-1:0] rx_rate_id,
    input  logic             ts_valid,
    input  logic             st_cfg_done,
    input  logic             st_rcvr_cfg,
    input  logic             dl_active,
    input  logic             port_is_dsp,
    input  logic [SPD_W-1:0] tgt_speed,
    input  logic             retrain_wr,
    input  logic             init_upg_dis,
    input  logic             rel_down_req,
    input  logic [SPD_W-1:0] cur_speed,
    input  logic             chg_ack,
    input  logic             bw_sts_clr,
    output logic             chg_req,
    output logic [SPD_W-1:0] chg_speed,
    output logic [SPD_W-1:0] adv_speeds,
    output logic [SPD_W-1:0] partner_caps,
    output logic             link_retrain,
    output logic             bw_sts
);
    logic             issue;
    logic [SPD_W-1:0] issue_speed;
    chg_src_e         issue_src;

    lrc_partner_caps caps_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ts_valid    (ts_valid),
        .st_cfg_done (st_cfg_done),
        .st_rcvr_cfg (st_rcvr_cfg),
        .rx_rate_id  (rx_rate_id),
        .caps        (partner_caps)
    );

    lrc_arbiter arb_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .partner_gen2 (partner_caps[1]),
        .tgt_speed    (tgt_speed),
        .cur_speed    (cur_speed),
        .dl_active    (dl_active),
        .port_is_dsp  (port_is_dsp),
        .init_upg_dis (init_upg_dis),
        .retrain_wr   (retrain_wr),
        .rel_down_req (rel_down_req),
        .busy         (chg_req),
        .link_retrain (link_retrain),
        .issue        (issue),
        .issue_speed  (issue_speed),
        .issue_src    (issue_src)
    );

    lrc_req_hold req_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue       (issue),
        .issue_speed (issue_speed),
        .issue_src   (issue_src),
        .chg_ack     (chg_ack),
        .bw_sts_clr  (bw_sts_clr),
        .chg_req     (chg_req),
        .chg_speed   (chg_speed),
        .bw_sts      (bw_sts)
    );

    // Advertised speeds follow the target field.
    assign adv_speeds = (partner_caps[0] && tgt_speed == SPD_GEN2) ? CAPS_ALL : SPD_GEN1;
endmodule

// File: rtl/lrc_checker.sv
// Checker: temporal properties of link_rate_ctrl, attached by bind below.
module lrc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       ts_valid,
    input logic       st_cfg_done,
    input logic       st_rcvr_cfg,
    input logic       rx_gen2,
    input logic [1:0] partner_caps,
    input logic       chg_req,
    input logic       chg_ack,
    input logic [1:0] chg_speed,
    input logic       link_retrain,
    input logic       retrain_wr,
    input logic       port_is_dsp,
    input logic       rel_down_req
);
    logic cap_now;
    assign cap_now = ts_valid && (st_cfg_done || st_rcvr_cfg);

    assert_caps_latest_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cap_now |=> partner_caps == {$past(rx_gen2), 1'b1});

    assert_caps_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_now |=> $stable(partner_caps));

    assert_gen2_needs_partner_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(chg_req) && chg_speed == 2'b10) |-> $past(partner_caps[1]));

    assert_hold_until_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_req && !chg_ack) |=> (chg_req && $stable(chg_speed)));

    assert_drop_on_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_req && chg_ack) |=> !chg_req);

    assert_upstream_no_auto_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(chg_req) && !$past(link_retrain) && !$past(rel_down_req)) |-> $past(port_is_dsp));

    assert_retrain_self_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (link_retrain && !chg_req && !retrain_wr) |=> !link_retrain);
endmodule

bind link_rate_ctrl lrc_checker chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .ts_valid     (ts_valid),
    .st_cfg_done  (st_cfg_done),
    .st_rcvr_cfg  (st_rcvr_cfg),
    .rx_gen2      (rx_rate_id[1]),
    .partner_caps (partner_caps),
    .chg_req      (chg_req),
    .chg_ack      (chg_ack),
    .chg_speed    (chg_speed),
    .link_retrain (link_retrain),
    .retrain_wr   (retrain_wr),
    .port_is_dsp  (port_is_dsp),
    .rel_down_req (rel_down_req)
);

// File: tb/link_rate_ctrl_tb_top.sv
module link_rate_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] rx_rate_id = 2'b01;
    logic       ts_valid = 1'b0, st_cfg_done = 1'b0, st_rcvr_cfg = 1'b0;
    logic       dl_active = 1'b0, port_is_dsp = 1'b1;
    logic [1:0] tgt_speed = 2'b10;
    logic       retrain_wr = 1'b0, init_upg_dis = 1'b0, rel_down_req = 1'b0;
    logic [1:0] cur_speed = 2'b01;
    logic       chg_ack = 1'b0, bw_sts_clr = 1'b0;
    logic       chg_req, link_retrain, bw_sts;
    logic [1:0] chg_speed, adv_speeds, partner_caps;

    int n_checks = 0;
    int n_errors = 0;

    always #10 clk = ~clk;

    link_rate_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .rx_rate_id(rx_rate_id), .ts_valid(ts_valid),
        .st_cfg_done(st_cfg_done), .st_rcvr_cfg(st_rcvr_cfg), .dl_active(dl_active),
        .port_is_dsp(port_is_dsp), .tgt_speed(tgt_speed), .retrain_wr(retrain_wr),
        .init_upg_dis(init_upg_dis), .rel_down_req(rel_down_req), .cur_speed(cur_speed),
        .chg_ack(chg_ack), .bw_sts_clr(bw_sts_clr), .chg_req(chg_req),
        .chg_speed(chg_speed), .adv_speeds(adv_speeds), .partner_caps(partner_caps),
        .link_retrain(link_retrain), .bw_sts(bw_sts)
    );

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic capture(input logic [1:0] id, input bit rcvr);
        rx_rate_id = id; ts_valid = 1'b1;
        st_cfg_done = !rcvr; st_rcvr_cfg = rcvr;
        step();
        ts_valid = 1'b0; st_cfg_done = 1'b0; st_rcvr_cfg = 1'b0;
    endtask

    task automatic t_reset();
        check("R3 reset caps", partner_caps, 2'b01);
        check("R3 reset adv", adv_speeds, 2'b11);
        check("R10 reset req", chg_req, 1'b0);
        check("R11 reset bw", bw_sts, 1'b0);
        check("R8 reset retrain", link_retrain, 1'b0);
    endtask

    task automatic t_capture();
        rx_rate_id = 2'b11; ts_valid = 1'b1;
        step();
        ts_valid = 1'b0;
        check("R1 no state strobe", partner_caps, 2'b01);
        st_cfg_done = 1'b1;
        step();
        st_cfg_done = 1'b0;
        check("R1 strobe without ts", partner_caps, 2'b01);
        capture(2'b11, 1'b0);
        check("R2 cfg capture", partner_caps, 2'b11);
        capture(2'b00, 1'b1);
        check("R2 latest wins down", partner_caps, 2'b01);
        capture(2'b10, 1'b1);
        check("R2 rcvr capture", partner_caps, 2'b11);
    endtask

    task automatic t_adv();
        tgt_speed = 2'b01; #1;
        check("R3 adv gen1 target", adv_speeds, 2'b01);
        tgt_speed = 2'b10; #1;
        check("R3 adv gen2 target", adv_speeds, 2'b11);
    endtask

    task automatic t_upstream();
        port_is_dsp = 1'b0; dl_active = 1'b1;
        step(3);
        check("R5 upstream no auto", chg_req, 1'b0);
        dl_active = 1'b0; port_is_dsp = 1'b1;
        step();
    endtask

    task automatic t_disable();
        init_upg_dis = 1'b1; dl_active = 1'b1;
        step(3);
        check("R5 disable bit blocks", chg_req, 1'b0);
        dl_active = 1'b0; init_upg_dis = 1'b0;
        step();
    endtask

    task automatic t_auto();
        dl_active = 1'b1;
        step();
        check("R4 auto req", chg_req, 1'b1);
        check("R4 auto speed", chg_speed, 2'b10);
        step(3);
        check("R10 held without ack", chg_req, 1'b1);
        chg_ack = 1'b1;
        step();
        chg_ack = 1'b0; cur_speed = 2'b01;
        check("R10 drop on ack", chg_req, 1'b0);
        check("R11 auto no status", bw_sts, 1'b0);
        step(2);
        check("R6 once per period", chg_req, 1'b0);
        dl_active = 1'b0;
        step();
        dl_active = 1'b1;
        step();
        check("R6 rearm", chg_req, 1'b1);
        chg_ack = 1'b1; cur_speed = 2'b10;
        step();
        chg_ack = 1'b0; dl_active = 1'b0;
        step();
    endtask

    task automatic t_retrain_down();
        tgt_speed = 2'b01; retrain_wr = 1'b1;
        step();
        retrain_wr = 1'b0;
        check("R8 retrain set", link_retrain, 1'b1);
        step();
        check("R8 retrain cleared", link_retrain, 1'b0);
        check("R7 retrain req", chg_req, 1'b1);
        check("R7 retrain speed", chg_speed, 2'b01);
        chg_ack = 1'b1;
        step();
        chg_ack = 1'b0; cur_speed = 2'b01;
        check("R11 sw status set", bw_sts, 1'b1);
        bw_sts_clr = 1'b1;
        step();
        bw_sts_clr = 1'b0;
        check("R11 status clear", bw_sts, 1'b0);
    endtask

    task automatic t_retrain_up();
        capture(2'b01, 1'b0);
        tgt_speed = 2'b10; retrain_wr = 1'b1;
        step();
        retrain_wr = 1'b0;
        step();
        check("R7 no partner gen2", chg_req, 1'b0);
        check("R8 cleared w/o req", link_retrain, 1'b0);
        capture(2'b11, 1'b1);
        retrain_wr = 1'b1;
        step();
        retrain_wr = 1'b0;
        step();
        check("R7 up req", chg_req, 1'b1);
        check("R7 up speed", chg_speed, 2'b10);
        chg_ack = 1'b1;
        step();
        chg_ack = 1'b0; cur_speed = 2'b10;
        check("R11 up status", bw_sts, 1'b1);
        bw_sts_clr = 1'b1;
        step();
        bw_sts_clr = 1'b0;
    endtask

    task automatic t_reliability();
        rel_down_req = 1'b1;
        step();
        rel_down_req = 1'b0;
        check("R9 rel req", chg_req, 1'b1);
        check("R9 rel speed", chg_speed, 2'b01);
        retrain_wr = 1'b1;
        step();
        retrain_wr = 1'b0;
        step(2);
        check("R8 retrain waits", link_retrain, 1'b1);
        check("R10 speed stable", chg_speed, 2'b01);
        chg_ack = 1'b1;
        step();
        chg_ack = 1'b0;
        check("R11 rel status", bw_sts, 1'b1);
        step();
        check("R8 accepted after idle", link_retrain, 1'b0);
        check("R7 same speed no req", chg_req, 1'b0);
        cur_speed = 2'b01; rel_down_req = 1'b1;
        step();
        rel_down_req = 1'b0;
        check("R9 ignored at gen1", chg_req, 1'b0);
        bw_sts_clr = 1'b1;
        step();
        bw_sts_clr = 1'b0;
    endtask

    task automatic t_priority();
        retrain_wr = 1'b1;
        step();
        retrain_wr = 1'b0; dl_active = 1'b1;
        step();
        check("R12 req issued", chg_req, 1'b1);
        chg_ack = 1'b1; cur_speed = 2'b10;
        step();
        chg_ack = 1'b0;
        check("R12 retrain served", bw_sts, 1'b1);
        step();
        check("R12 no extra req", chg_req, 1'b0);
        dl_active = 1'b0;
    endtask

    initial begin
        #(20 * 100000);
        n_errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step();
        t_reset();
        t_capture();
        t_adv();
        t_upstream();
        t_disable();
        t_auto();
        t_retrain_down();
        t_retrain_up();
        t_reliability();
        t_priority();
        step(2);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule